// File: doc/BRIEF.md
# Program Counter with Boot Vector Fetch

This block holds the 16-bit address of the next instruction for a small 8-bit controller core. It does not start at a hard-wired address. When reset is released it reads a two-byte start vector from the lowest program-memory locations through a byte-wide read port, one byte per cycle, and assembles the start address from those bytes. Only after both bytes are in does it raise its ready flag and begin normal operation.

While ready, the counter moves forward by the byte length of the instruction just fetched, which the decoder supplies with a step strobe. On a jump strobe it takes a full 16-bit target, which the core may source from an immediate field or from a register. A jump wins over a step in the same cycle. The read address port shows the vector location during the boot fetch and the counter value afterwards, so the same memory port serves both phases. The program memory is combinational here: read data belongs to the address driven in the same cycle.

Top module: `pcu_core`

## Requirements
- R1: While reset (active low) is held, the counter reads 0000H, ready is low and the read address is 0000H.
- R2: After reset is released, the read address is 0000H in the first cycle and 0001H in the second, and the read data present in each of those cycles is captured at the closing clock edge.
- R3: The byte read at 0000H becomes counter bits 7:0 and the byte read at 0001H becomes bits 15:8; ready rises at the second clock edge after release, with the counter then equal to the full vector.
- R4: Once high, ready stays high until reset is applied again.
- R5: While ready is high, the read address equals the counter value.
- R6: While ready is high, a step strobe with a length of 1, 2, 3 or 4 (the length input read as an unsigned number) adds that length to the counter at the next clock edge.
- R7: The stepped counter wraps modulo 65536.
- R8: While ready is high, a jump strobe loads the jump target into the counter at the next clock edge.
- R9: When step and jump strobes are both high in one cycle, the jump target is loaded and the step is discarded.
- R10: Step and jump strobes during the boot fetch have no effect: the counter still ends up equal to the vector.
- R11: With neither strobe high while ready, the counter keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_rdata | input | 8 | Program-memory read data for the current read address |
| step_len | input | 3 | Byte length of the fetched instruction, 1 to 4 |
| step_en | input | 1 | Advance the counter by step_len |
| jump_en | input | 1 | Load the counter with jump_addr |
| jump_addr | input | 16 | Branch target |
| pc_o | output | 16 | Current counter value |
| mem_addr | output | 16 | Program-memory read address |
| ready | output | 1 | Boot vector loaded, normal operation active |

## Verification
The bench holds step and jump strobes high through the whole boot fetch; a design that honoured them early would finish with a counter other than the vector. It uses vectors whose two bytes differ so that swapped byte lanes show up at once, and checks the cycle of the ready rise so a design with one cycle too many or too few in the fetch is caught. It steps across the top of the address space to catch a missing wrap or a widened carry, and pairs a jump with a step in one cycle, where a design with the wrong priority lands on the stepped address.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
   typedef enum logic [0:0] {
      PH_BOOT = 1'b0,
      PH_RUN  = 1'b1
   } pcu_phase_e;
endpackage

// File: rtl/pcu_boot_seq.sv
module pcu_boot_seq
   import pcu_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int DATA_W   = 8,
   parameter int VEC_BASE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   output pcu_phase_e        phase,
   output logic [ADDR_W/DATA_W-1:0] lane_we,
   output logic [ADDR_W-1:0] boot_addr
);
   localparam int NB    = ADDR_W / DATA_W;
   localparam int IDX_W = (NB > 1) ? $clog2(NB) : 1;

   logic [IDX_W-1:0] idx_q;
   pcu_phase_e       phase_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q   <= '0;
         phase_q <= PH_BOOT;
      end else if (phase_q == PH_BOOT) begin
         if (idx_q == IDX_W'(NB - 1)) begin
            phase_q <= PH_RUN;
         end else begin
            idx_q <= idx_q + 1'b1;
         end
      end
   end

   for (genvar g = 0; g < NB; g++) begin : g_lane
      assign lane_we[g] = (phase_q == PH_BOOT) && (idx_q == IDX_W'(g));
   end

   assign phase     = phase_q;
   assign boot_addr = ADDR_W'(VEC_BASE) + ADDR_W'(idx_q);

   AST_BOOT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_BOOT && idx_q != IDX_W'(NB - 1)) |=> boot_addr == $past(boot_addr) + 1'b1); // R2
   AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_RUN) |=> (phase_q == PH_RUN)); // R4
endmodule

// File: rtl/pcu_next_calc.sv
module pcu_next_calc #(
   parameter int ADDR_W = 16,
   parameter int LEN_W  = 3
) (
   input  logic [ADDR_W-1:0] pc,
   input  logic              step_en,
   input  logic [LEN_W-1:0]  step_len,
   input  logic              jump_en,
   input  logic [ADDR_W-1:0] jump_addr,
   output logic [ADDR_W-1:0] nxt,
   output logic              upd
);
   logic [ADDR_W-1:0] len_ext;

   if (LEN_W < ADDR_W) begin : g_zext
      assign len_ext = {{(ADDR_W - LEN_W){1'b0}}, step_len};
   end else begin : g_trunc
      assign len_ext = step_len[ADDR_W-1:0];
   end

   always_comb begin
      upd = jump_en || step_en;
      if (jump_en) begin
         nxt = jump_addr;
      end else if (step_en) begin
         nxt = pc + len_ext;
      end else begin
         nxt = pc;
      end
   end
endmodule

// File: rtl/pcu_core.sv
module pcu_core
   import pcu_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int DATA_W   = 8,
   parameter int LEN_W    = 3,
   parameter int MAX_LEN  = 4,
   parameter int VEC_BASE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic [LEN_W-1:0]  step_len,
   input  logic              step_en,
   input  logic              jump_en,
   input  logic [ADDR_W-1:0] jump_addr,
   output logic [ADDR_W-1:0] pc_o,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              ready
);
   localparam int NB = ADDR_W / DATA_W;

   if (ADDR_W % DATA_W != 0) begin : g_chk_lanes
      $error("ADDR_W must be a whole number of DATA_W lanes");
   end
   if (MAX_LEN < 1 || MAX_LEN >= (1 << LEN_W)) begin : g_chk_len
      $error("MAX_LEN must fit in LEN_W bits and be at least 1");
   end
   if (VEC_BASE < 0 || VEC_BASE + NB > (1 << ADDR_W)) begin : g_chk_base
      $error("vector table must lie inside the address space");
   end

   pcu_phase_e        phase;
   logic [NB-1:0]     lane_we;
   logic [ADDR_W-1:0] boot_addr;
   logic [ADDR_W-1:0] nxt;
   logic              upd;
   logic [ADDR_W-1:0] pc_q;
   logic [ADDR_W-1:0] pc_d;
   logic              run;

   pcu_boot_seq #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .VEC_BASE(VEC_BASE)
   ) u_boot (
      .clk      (clk),
      .rst_n    (rst_n),
      .phase    (phase),
      .lane_we  (lane_we),
      .boot_addr(boot_addr)
   );

   pcu_next_calc #(
      .ADDR_W(ADDR_W),
      .LEN_W (LEN_W)
   ) u_next (
      .pc       (pc_q),
      .step_en  (step_en),
      .step_len (step_len),
      .jump_en  (jump_en),
      .jump_addr(jump_addr),
      .nxt      (nxt),
      .upd      (upd)
   );

   assign run = (phase == PH_RUN);

   always_comb begin
      pc_d = pc_q;
      if (run) begin
         if (upd) pc_d = nxt;
      end else begin
         for (int i = 0; i < NB; i++) begin
            if (lane_we[i]) pc_d[i*DATA_W +: DATA_W] = mem_rdata;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pc_q <= '0;
      else        pc_q <= pc_d;
   end

   assign pc_o     = pc_q;
   assign ready    = run;
   assign mem_addr = run ? pc_q : boot_addr;

   AST_RUN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> mem_addr == pc_o); // R5
   AST_JUMP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && jump_en) |=> pc_o == $past(jump_addr)); // R8
   AST_STEP_ADD: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && step_en && !jump_en) |=> pc_o == $past(pc_o) + ADDR_W'($past(step_len))); // R6
   AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && step_en && !jump_en) |-> (step_len >= LEN_W'(1) && step_len <= LEN_W'(MAX_LEN))); // R6
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && !step_en && !jump_en) |=> $stable(pc_o)); // R11
endmodule

// File: tb/sim_pcu_core.sv
`timescale 1ns/1ps
module sim_pcu_core;
   typedef struct packed {
      logic [15:0] pc;
      logic [15:0] addr;
      logic        rdy;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  mem_rdata;
   logic [2:0]  step_len = 3'd0;
   logic        step_en = 1'b0;
   logic        jump_en = 1'b0;
   logic [15:0] jump_addr = 16'h0;
   logic [15:0] pc_o;
   logic [15:0] mem_addr;
   logic        ready;

   logic [7:0]  vec_lo = 8'h34;
   logic [7:0]  vec_hi = 8'h12;
   logic [15:0] m_pc = 16'h0;

   exp_t  q_exp[$];
   string q_req[$];
   int    n_chk = 0;
   int    n_bad = 0;
   bit    done = 1'b0;

   always #2.5 clk = ~clk;

   assign mem_rdata = (mem_addr == 16'h0000) ? vec_lo :
                      (mem_addr == 16'h0001) ? vec_hi : 8'h00;

   pcu_core u0 (
      .clk(clk), .rst_n(rst_n), .mem_rdata(mem_rdata), .step_len(step_len),
      .step_en(step_en), .jump_en(jump_en), .jump_addr(jump_addr),
      .pc_o(pc_o), .mem_addr(mem_addr), .ready(ready)
   );

   task automatic push(input logic [15:0] pc, input logic [15:0] addr,
                       input logic rdy, input string req);
      exp_t e;
      e.pc = pc; e.addr = addr; e.rdy = rdy;
      q_exp.push_back(e);
      q_req.push_back(req);
   endtask

   task automatic check(input string what, input string req,
                        input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // Monitor: compares one scoreboard item per falling edge.
   always @(negedge clk) begin
      if (q_exp.size() > 0) begin
         exp_t  e;
         string r;
         e = q_exp.pop_front();
         r = q_req.pop_front();
         check("pc", r, pc_o, e.pc);
         check("addr", r, mem_addr, e.addr);
         check("ready", r, {15'h0, ready}, {15'h0, e.rdy});
      end
   end

   // Reset and boot fetch, with strobes held high the whole time (R10).
   task automatic boot(input logic [7:0] lo, input logic [7:0] hi);
      @(negedge clk);
      rst_n = 1'b0; vec_lo = lo; vec_hi = hi;
      step_en = 1'b1; step_len = 3'd4; jump_en = 1'b1; jump_addr = 16'hBEEF;
      @(posedge clk); #1;
      push(16'h0000, 16'h0000, 1'b0, "R1");
      @(negedge clk); #0.5;
      rst_n = 1'b1;
      @(posedge clk); #1;
      push({8'h00, lo}, 16'h0001, 1'b0, "R2");
      @(posedge clk); #1;
      push({hi, lo}, {hi, lo}, 1'b1, "R3 R10");
      m_pc = {hi, lo};
      @(negedge clk);
      step_en = 1'b0; jump_en = 1'b0;
   endtask

   // One operating cycle; expected state computed from the requirements.
   task automatic op(input logic s, input logic [2:0] len, input logic j,
                     input logic [15:0] ja, input string req);
      @(negedge clk);
      step_en = s; step_len = len; jump_en = j; jump_addr = ja;
      if (j)      m_pc = ja;
      else if (s) m_pc = m_pc + {13'h0, len};
      @(posedge clk); #1;
      push(m_pc, m_pc, 1'b1, req);
      @(negedge clk);
      step_en = 1'b0; jump_en = 1'b0;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      boot(8'h34, 8'h12);
      op(1'b0, 3'd0, 1'b0, 16'h0, "R11 R4 R5");
      op(1'b1, 3'd1, 1'b0, 16'h0, "R6");
      op(1'b1, 3'd2, 1'b0, 16'h0, "R6");
      op(1'b1, 3'd3, 1'b0, 16'h0, "R6");
      op(1'b1, 3'd4, 1'b0, 16'h0, "R6");
      op(1'b0, 3'd0, 1'b1, 16'h8000, "R8");
      op(1'b1, 3'd3, 1'b1, 16'h4321, "R9");
      op(1'b0, 3'd0, 1'b1, 16'hFFFE, "R8");
      op(1'b1, 3'd3, 1'b0, 16'h0, "R7");
      op(1'b1, 3'd4, 1'b0, 16'h0, "R6");
      op(1'b0, 3'd0, 1'b0, 16'h0, "R11");
      boot(8'hFF, 8'hFF);
      op(1'b1, 3'd1, 1'b0, 16'h0, "R7");
      boot(8'h5A, 8'hA5);
      op(1'b0, 3'd0, 1'b0, 16'h0, "R4 R11");
      op(1'b1, 3'd2, 1'b1, 16'h0102, "R9");
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule